// File: doc/BRIEF.md
# Packed Palette RAM Loader

This block is a colour lookup table of 256 entries, each holding a red, a green and a blue byte. Software fills it through a small register strobe interface. It first writes a starting entry index to an index register. It then streams 32-bit words to a data port. Each word carries four component bytes, which land at four consecutive component positions in entry-major order (red, green, blue, then red of the next entry). Three words therefore fill exactly four entries, and one word may straddle two entries. An internal byte pointer advances after every transfer, so a whole palette loads after a single index write.

The same data port streams components back one byte per read, moving the same pointer in the same order. A separate pixel port turns an 8-bit index into a 24-bit RGB value with one cycle of latency. The storage is four byte-wide lanes with one write port each. Every data word therefore finishes in a single cycle, whatever its alignment.

Top module: `palette_loader`

## Requirements
- R1: Synchronous active-high reset puts the pointer at entry 0, red component, and drives reg_rdata to zero. Data words written after reset with no index write fill the table from entry 0.
- R2: A write with reg_addr = 0x00 loads the pointer from reg_wdata[7:0] as that entry's red component. This realigns the pointer even after byte reads have left it partway through an entry.
- R3: A write with reg_addr = 0x04 places reg_wdata[31:24], [23:16], [15:8] and [7:0] at the pointer and the next three component positions, in that order. Positions run red, green, blue of one entry, then red of the next. The pointer then advances by four components, so three words fill four entries.
- R4: Data words may arrive on consecutive cycles after a single index write, with no gap or further index write.
- R5: Stepping past entry 255, blue component, wraps the pointer to entry 0, red component, for both writes and reads.
- R6: A read with reg_addr = 0x04 returns the component at the pointer in reg_rdata[7:0] on the next cycle, with bits [31:8] zero, and advances the pointer by one component.
- R7: pix_rgb shows {red, green, blue} of the entry on pix_index one cycle later. If the same edge writes that entry, the old contents are returned, and the new ones appear on the following cycle.
- R8: A read in the same cycle as a write is ignored: reg_rdata stays zero and only the write moves the pointer. Reads at any offset other than 0x04 return zero and leave the pointer alone. Writes at any offset other than 0x00 and 0x04 change neither the pointer nor the table.
- R9: A data word written while the pointer is not on a red component still lands on the next four consecutive component positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register byte offset (0x00 index, 0x04 data) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_rd |
| pix_index | input | 8 | Pixel lookup index |
| pix_rgb | output | 24 | Looked-up colour {red, green, blue} |

## Verification
Two functions can fall in the same cycle. A data write can update an entry on the same edge that the pixel port reads that entry. The bench holds pix_index on the entry under the pointer while it strobes a data word. It expects the old colour one cycle later and the new colour one cycle after that. A read strobe can also coincide with a write strobe. That case is judged by a zero reg_rdata, followed by a readback showing the pointer moved by exactly four components.

// File: rtl/palette_pkg.sv
package palette_pkg;

  localparam int OFS_INDEX = 0;
  localparam int OFS_DATA  = 4;

  typedef enum logic [1:0] {
    ACC_NONE,
    ACC_LOAD,
    ACC_WRITE,
    ACC_READ
  } acc_e;

  // modular add for small steps (step < lim)
  function automatic int wrap_sum(input int a, input int step, input int lim);
    int s;
    s = a + step;
    if (s >= lim) s = s - lim;
    return s;
  endfunction

endpackage

// File: rtl/palette_ptr.sv
module palette_ptr #(
  parameter int ENTRIES = 256,
  localparam int BYTES = 3 * ENTRIES,
  localparam int IDX_W = $clog2(ENTRIES),
  localparam int PTR_W = $clog2(BYTES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [IDX_W-1:0] load_idx,
  input  logic             adv4,
  input  logic             adv1,
  output logic [PTR_W-1:0] ptr
);
  import palette_pkg::*;

  logic [PTR_W-1:0] ptr_d;

  always_comb begin
    ptr_d = ptr;
    if (load)
      ptr_d = PTR_W'((int'(load_idx) % ENTRIES) * 3);
    else if (adv4)
      ptr_d = PTR_W'(wrap_sum(int'(ptr), 4, BYTES));
    else if (adv1)
      ptr_d = PTR_W'(wrap_sum(int'(ptr), 1, BYTES));
  end

  always_ff @(posedge clk) begin
    if (rst) ptr <= '0;
    else     ptr <= ptr_d;
  end

endmodule

// File: rtl/palette_lane.sv
module palette_lane #(
  parameter int DEPTH = 192,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] ra_addr,
  output logic [W-1:0]  ra_data,
  input  logic [AW-1:0] rb_addr,
  output logic [W-1:0]  rb_data
);

  logic [W-1:0] mem [DEPTH];

  // read-first: a same-edge write is seen on the next read
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    ra_data <= mem[ra_addr];
    rb_data <= mem[rb_addr];
  end

endmodule

// File: rtl/palette_pix_addr.sv
module palette_pix_addr #(
  parameter int ENTRIES = 256,
  localparam int BYTES = 3 * ENTRIES,
  localparam int ROWS  = BYTES / 4,
  localparam int IDX_W = $clog2(ENTRIES),
  localparam int PTR_W = $clog2(BYTES),
  localparam int ROW_W = $clog2(ROWS)
) (
  input  logic [IDX_W-1:0] pix_index,
  output logic [ROW_W-1:0] row [4],
  output logic [1:0]       base_lane
);
  import palette_pkg::*;

  logic [PTR_W-1:0] base;

  assign base      = PTR_W'({pix_index, 1'b0}) + PTR_W'(pix_index);
  assign base_lane = base[1:0];

  for (genvar L = 0; L < 4; L++) begin : g_row
    logic [1:0] comp;
    int         pos;
    always_comb begin
      comp   = 2'(L) - base[1:0];
      pos    = wrap_sum(int'(base), int'(comp), BYTES);
      row[L] = ROW_W'(pos >> 2);
    end
  end

endmodule

// File: rtl/palette_loader.sv
module palette_loader #(
  parameter int ENTRIES = 256,
  parameter int CW      = 8,
  parameter int REG_AW  = 4,
  localparam int DATA_W = 4 * CW,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [IDX_W-1:0]  pix_index,
  output logic [3*CW-1:0]   pix_rgb
);
  import palette_pkg::*;

  localparam int BYTES = 3 * ENTRIES;
  localparam int ROWS  = BYTES / 4;
  localparam int PTR_W = $clog2(BYTES);
  localparam int ROW_W = $clog2(ROWS);

  acc_e             acc;
  logic [PTR_W-1:0] ptr_q;
  logic [ROW_W-1:0] pix_row [4];
  logic [1:0]       pix_lane;
  logic [1:0]       pix_lane_q;
  logic [1:0]       rd_lane_q;
  logic             rd_hit_q;
  logic [CW-1:0]    dout_pix [4];
  logic [CW-1:0]    dout_rd  [4];

  // access decode: writes win over a same-cycle read
  always_comb begin
    acc = ACC_NONE;
    if (reg_wr) begin
      if (reg_addr == REG_AW'(OFS_INDEX))     acc = ACC_LOAD;
      else if (reg_addr == REG_AW'(OFS_DATA)) acc = ACC_WRITE;
    end else if (reg_rd && reg_addr == REG_AW'(OFS_DATA)) begin
      acc = ACC_READ;
    end
  end

  palette_ptr #(.ENTRIES(ENTRIES)) u_ptr (
    .clk      (clk),
    .rst      (rst),
    .load     (acc == ACC_LOAD),
    .load_idx (reg_wdata[IDX_W-1:0]),
    .adv4     (acc == ACC_WRITE),
    .adv1     (acc == ACC_READ),
    .ptr      (ptr_q)
  );

  palette_pix_addr #(.ENTRIES(ENTRIES)) u_pix_addr (
    .pix_index (pix_index),
    .row       (pix_row),
    .base_lane (pix_lane)
  );

  // one byte-wide lane per byte address modulo four
  for (genvar L = 0; L < 4; L++) begin : g_lane
    logic [1:0]       slot;
    int               pos;
    logic [ROW_W-1:0] wrow;
    logic [CW-1:0]    wbyte;

    always_comb begin
      slot  = 2'(L) - ptr_q[1:0];
      pos   = wrap_sum(int'(ptr_q), int'(slot), BYTES);
      wrow  = ROW_W'(pos >> 2);
      wbyte = reg_wdata[DATA_W-1 - int'(slot)*CW -: CW];
    end

    palette_lane #(.DEPTH(ROWS), .W(CW)) u_lane (
      .clk     (clk),
      .we      (acc == ACC_WRITE),
      .waddr   (wrow),
      .wdata   (wbyte),
      .ra_addr (pix_row[L]),
      .ra_data (dout_pix[L]),
      .rb_addr (ROW_W'(ptr_q >> 2)),
      .rb_data (dout_rd[L])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pix_lane_q <= '0;
      rd_lane_q  <= '0;
      rd_hit_q   <= 1'b0;
    end else begin
      pix_lane_q <= pix_lane;
      rd_lane_q  <= ptr_q[1:0];
      rd_hit_q   <= (acc == ACC_READ);
    end
  end

  assign reg_rdata = rd_hit_q ? DATA_W'(dout_rd[rd_lane_q]) : '0;

  for (genvar C = 0; C < 3; C++) begin : g_comp
    assign pix_rgb[3*CW-1 - C*CW -: CW] = dout_pix[pix_lane_q + 2'(C)];
  end

endmodule

// File: rtl/palette_loader_chk.sv
module palette_loader_chk #(
  parameter int ENTRIES = 256,
  parameter int CW      = 8,
  parameter int REG_AW  = 4,
  localparam int DATA_W = 4 * CW,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int BYTES  = 3 * ENTRIES,
  localparam int PTR_W  = $clog2(BYTES)
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [REG_AW-1:0] reg_addr,
  input logic [IDX_W-1:0]  wr_idx,
  input logic [DATA_W-1:0] reg_rdata,
  input logic [PTR_W-1:0]  ptr
);
  import palette_pkg::*;

  logic at_idx, at_dat;
  assign at_idx = (reg_addr == REG_AW'(OFS_INDEX));
  assign at_dat = (reg_addr == REG_AW'(OFS_DATA));

  assert_reset_ptr_R1: assert property (@(posedge clk)
    rst |=> ptr == '0);

  assert_load_red_R2: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && at_idx) |=>
      int'(ptr) == (int'($past(wr_idx)) % ENTRIES) * 3);

  assert_step_four_R3: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && at_dat) |=>
      int'(ptr) == wrap_sum(int'($past(ptr)), 4, BYTES));

  assert_step_one_R6: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && !reg_wr && at_dat) |=>
      int'(ptr) == wrap_sum(int'($past(ptr)), 1, BYTES));

  assert_ptr_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!(reg_wr && (at_idx || at_dat)) && !(reg_rd && at_dat)) |=> $stable(ptr));

  assert_rdata_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    !(reg_rd && !reg_wr && at_dat) |=> reg_rdata == '0);

endmodule

bind palette_loader palette_loader_chk #(
  .ENTRIES (ENTRIES),
  .CW      (CW),
  .REG_AW  (REG_AW)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_wr    (reg_wr),
  .reg_rd    (reg_rd),
  .reg_addr  (reg_addr),
  .wr_idx    (reg_wdata[IDX_W-1:0]),
  .reg_rdata (reg_rdata),
  .ptr       (ptr_q)
);

// File: tb/palette_loader_tb.sv
module palette_loader_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NB = 768;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [7:0]  pix_index = '0;
  logic [23:0] pix_rgb;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  logic [7:0] m_mem [NB];
  int         m_ptr = 0;

  // {start index, word0, word1, word2}
  localparam logic [103:0] VEC [6] = '{
    {8'd0,   32'h11223344, 32'h55667788, 32'h99AABBCC},
    {8'd4,   32'hA1A2A3A4, 32'hB1B2B3B4, 32'hC1C2C3C4},
    {8'd60,  32'h00FF00FF, 32'hFF00FF00, 32'h0F0F0F0F},
    {8'd128, 32'hDEADBEEF, 32'hCAFEF00D, 32'h01234567},
    {8'd200, 32'h89ABCDEF, 32'h13579BDF, 32'h2468ACE0},
    {8'd124, 32'h5A5A5A5A, 32'hA5A5A5A5, 32'h3C3CC3C3}
  };

  palette_loader u_dut (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .pix_index (pix_index),
    .pix_rgb   (pix_rgb)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] exp_rgb(input int e);
    return {m_mem[3*e], m_mem[3*e+1], m_mem[3*e+2]};
  endfunction

  task automatic model_word(input logic [31:0] w);
    for (int k = 0; k < 4; k++) m_mem[(m_ptr + k) % NB] = w[31-8*k -: 8];
    m_ptr = (m_ptr + 4) % NB;
  endtask

  task automatic idle();
    @(negedge clk);
    reg_wr = 1'b0;
    reg_rd = 1'b0;
  endtask

  task automatic set_index(input int idx);
    @(negedge clk);
    reg_wr = 1'b1; reg_rd = 1'b0; reg_addr = 4'h0; reg_wdata = 32'(idx);
    m_ptr = idx * 3;
  endtask

  task automatic put_word(input logic [31:0] w);
    @(negedge clk);
    reg_wr = 1'b1; reg_rd = 1'b0; reg_addr = 4'h4; reg_wdata = w;
    model_word(w);
  endtask

  task automatic chk_pix(input string req, input int e);
    @(negedge clk);
    reg_wr = 1'b0; reg_rd = 1'b0;
    pix_index = 8'(e);
    @(negedge clk);
    chk(req, {8'h0, pix_rgb}, {8'h0, exp_rgb(e)});
  endtask

  task automatic chk_read(input string req);
    @(negedge clk);
    reg_wr = 1'b0; reg_rd = 1'b1; reg_addr = 4'h4;
    @(negedge clk);
    reg_rd = 1'b0;
    chk(req, reg_rdata, {24'h0, m_mem[m_ptr]});
    m_ptr = (m_ptr + 1) % NB;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 rdata after reset", reg_rdata, 32'h0);
    rst = 1'b0;

    // R1: data from entry 0 without an index write
    put_word(32'h10203040); put_word(32'h50607080); put_word(32'h90A0B0C0);
    idle();
    for (int e = 0; e < 4; e++) chk_pix("R1 fill from entry 0", e);

    // R2 R3 R4 R7: table of packed groups, streamed back to back
    foreach (VEC[v]) begin
      set_index(int'(VEC[v][103:96]));
      put_word(VEC[v][95:64]);
      put_word(VEC[v][63:32]);
      put_word(VEC[v][31:0]);
      idle();
      for (int e = 0; e < 4; e++)
        chk_pix("R3 R4 packed group", int'(VEC[v][103:96]) + e);
    end

    // R6: readback streams components of entry 4 onwards
    set_index(4); idle();
    for (int i = 0; i < 7; i++) chk_read("R6 readback order");

    // R5: write wraps past entry 255 blue
    set_index(252);
    put_word(32'hE0E1E2E3); put_word(32'hE4E5E6E7);
    put_word(32'hE8E9EAEB); put_word(32'hF0F1F2F3);
    idle();
    for (int e = 252; e < 256; e++) chk_pix("R5 last group", e);
    chk_pix("R5 wrapped entry 0", 0);
    chk_read("R5 pointer after write wrap");
    // R5: read wraps past entry 255 blue
    set_index(255); idle();
    for (int i = 0; i < 4; i++) chk_read("R5 R6 read wrap");

    // R9: unaligned data word after one byte read
    set_index(16); idle();
    chk_read("R9 red before unaligned write");
    put_word(32'h77665544); idle();
    chk_pix("R9 entry 16", 16);
    chk_pix("R9 entry 17", 17);
    // R2: index write restores red alignment
    set_index(16); idle();
    chk_read("R2 realigned to red");

    // R7: same-edge write and lookup of entry 8
    set_index(8); idle();
    @(negedge clk);
    pix_index = 8'd8;
    begin
      logic [23:0] old_rgb;
      old_rgb = exp_rgb(8);
      reg_wr = 1'b1; reg_addr = 4'h4; reg_wdata = 32'hC0DEC0DE;
      model_word(32'hC0DEC0DE);
      @(negedge clk);
      reg_wr = 1'b0;
      chk("R7 old value on colliding write", {8'h0, pix_rgb}, {8'h0, old_rgb});
      @(negedge clk);
      chk("R7 new value next cycle", {8'h0, pix_rgb}, {8'h0, exp_rgb(8)});
    end

    // R8: read and write in the same cycle
    set_index(40);
    @(negedge clk);
    reg_wr = 1'b1; reg_rd = 1'b1; reg_addr = 4'h4; reg_wdata = 32'h31323334;
    model_word(32'h31323334);
    @(negedge clk);
    reg_wr = 1'b0; reg_rd = 1'b0;
    chk("R8 read ignored during write", reg_rdata, 32'h0);
    chk_read("R8 pointer moved by write only");
    // R8: read at index offset returns zero, no advance
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = 4'h0;
    @(negedge clk);
    reg_rd = 1'b0;
    chk("R8 read at index offset", reg_rdata, 32'h0);
    chk_read("R8 pointer unmoved by stray read");
    // R8: write at unused offset ignored
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 4'h8; reg_wdata = 32'hFFFFFFFF;
    @(negedge clk);
    reg_wr = 1'b0;
    chk_read("R8 pointer unmoved by stray write");
    chk_pix("R8 table unchanged", 41);

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule